// File: doc/BRIEF.md
# Octal GPIO Expander Register Bank

This block is the register core of an eight-pin parallel port expander. A bus controller reaches four byte-wide registers through a 2-bit index, a write strobe, write data and a combinational read-data bus. The four registers are the input view, the output latch, the read-back polarity mask and the direction mask. Toward the pads the block drives one output-value bus and one output-enable bus, and it takes in the raw pin levels.

Raw pin levels pass through a two-flop synchronizer. When the controller pulses a sample strobe, the synchronized byte is captured, so a byte read stays stable for the whole transfer. Pin 0 has an open-drain driver. It can only pull low, and writing a 1 to its latch releases the pin. Pins 1 to 7 are push-pull. A synchronous active-low reset loads the register defaults and keeps them loaded for as long as it is held.

Top module: `gpio_expander_regs`

## Requirements
- R1: After reset, reads give 0x00 at index 1 (output latch), 0xF0 at index 2 (polarity) and 0xFF at index 3 (direction, 1 = input), and pad_oe is 0x00.
- R2: Index 1 reads the output latch, index 2 the polarity mask and index 3 the direction mask. The read is combinational from the stored value.
- R3: A write with index 0 changes no register. Indexes 1 to 3 and the index-0 read all keep their previous values.
- R4: A write with index 1, 2 or 3 loads wr_data into that register only, at the clock edge where wr_en is high.
- R5: The index-0 read is built from the value captured on the clock edge where sample_strobe is high. That value is pin_in as it was two edges before the capture, for every pin whatever its direction. Without the strobe, the captured value holds.
- R6: In the index-0 read, bit n is inverted when polarity bit n is 1 and direction bit n is 1. Otherwise bit n is the captured level.
- R7: For pins 1 to 7, pad_oe[n] is the inverse of direction bit n and pad_out[n] equals output-latch bit n.
- R8: Pin 0 is open drain. pad_out[0] is always 0, and pad_oe[0] is 1 only while direction bit 0 is 0 and latch bit 0 is 0.
- R9: The index-1 read returns the latch contents even when the pin level differs or the pin is an input.
- R10: While rst_n is low at a clock edge, every register returns to its default, and the defaults hold until reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_idx | input | 2 | Register index: 0 input, 1 output, 2 polarity, 3 direction |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for reg_idx |
| sample_strobe | input | 1 | Capture the synchronized pin levels into the input view |
| pin_in | input | 8 | Raw pin levels from the pads |
| pad_out | output | 8 | Drive value per pin |
| pad_oe | output | 8 | Driver enable per pin |

## Verification
On every cycle, the assertions check four things: a write lands in the addressed register, a write to index 0 leaves all configuration stable, the captured input holds when no strobe comes, and an odd value written to the latch releases the open-drain pin. Several behaviours can only be shown by the bench's scenarios, because each depends on a sequence of operations. These are the reset defaults, the hold of those defaults during reset, the synchronizer latency and the polarity masking by direction. Latch-versus-pin read-back and the per-pin enable pattern also fall here. The bench exercises them with random writes, pin patterns and direct corner cases against a reference model.

// File: rtl/gpx_pkg.sv
// Shared types for the GPIO expander register bank.
// Assumes a fixed map of four registers addressed by a 2-bit index.
package gpx_pkg;
    localparam int unsigned IDX_W = 2;

    typedef enum logic [IDX_W-1:0] {
        IDX_IN  = 2'd0,
        IDX_OUT = 2'd1,
        IDX_POL = 2'd2,
        IDX_DIR = 2'd3
    } gpx_idx_e;
endpackage

// File: rtl/gpx_in_sync.sv
// Multi-stage synchronizer for the raw pin levels.
// Assumes each bit is independent. No bus coherency is claimed.
module gpx_in_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stg_q [STAGES];

    // Shift the pin levels through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
        end else begin
            stg_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpx_cfg_regs.sv
// Output latch, polarity mask and direction mask with their write decode.
// Assumes one write per cycle. A write to the input index is discarded.
module gpx_cfg_regs
    import gpx_pkg::*;
#(
    parameter int unsigned     WIDTH   = 8,
    parameter logic [WIDTH-1:0] OUT_RST = '0,
    parameter logic [WIDTH-1:0] POL_RST = 8'hF0,
    parameter logic [WIDTH-1:0] DIR_RST = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] dir_q
);
    // Load defaults in reset, otherwise update only the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= OUT_RST;
            pol_q <= POL_RST;
            dir_q <= DIR_RST;
        end else if (wr_en_i) begin
            unique case (gpx_idx_e'(idx_i))
                IDX_OUT: out_q <= wr_data_i;
                IDX_POL: pol_q <= wr_data_i;
                IDX_DIR: dir_q <= wr_data_i;
                default: ;
            endcase
        end
    end

    // R3
    in_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx_i == IDX_IN) |=> ($stable(out_q) && $stable(pol_q) && $stable(dir_q)));

    // R4
    out_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx_i == IDX_OUT) |=> (out_q == $past(wr_data_i)));

    // R4
    dir_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && idx_i == IDX_DIR) |=> (dir_q == $past(wr_data_i)));
endmodule

// File: rtl/gpx_pad_ctrl.sv
// Per-pin driver control. Bits set in OD_MASK are open drain and only
// pull low. The other pins are push-pull. Purely combinational.
module gpx_pad_ctrl #(
    parameter int unsigned      WIDTH   = 8,
    parameter logic [WIDTH-1:0] OD_MASK = 8'h01
) (
    input  logic [WIDTH-1:0] out_i,
    input  logic [WIDTH-1:0] dir_i,
    output logic [WIDTH-1:0] pad_out_o,
    output logic [WIDTH-1:0] pad_oe_o
);
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        if (OD_MASK[p]) begin : g_od
            // Open drain: drive a low only when the pin is an output holding 0.
            assign pad_out_o[p] = 1'b0;
            assign pad_oe_o[p]  = ~dir_i[p] & ~out_i[p];
        end else begin : g_pp
            // Push-pull: drive the latch value whenever the pin is an output.
            assign pad_out_o[p] = out_i[p];
            assign pad_oe_o[p]  = ~dir_i[p];
        end
    end
endmodule

// File: rtl/gpio_expander_regs.sv
// Register bank of an 8-pin port expander. It synchronizes the pins,
// captures them on a sample strobe, applies polarity to the input view of
// input pins, and drives the pad enables. Assumes the bus controller
// strobes sample_strobe before it reads index 0.
module gpio_expander_regs
    import gpx_pkg::*;
#(
    parameter int unsigned      WIDTH       = 8,
    parameter int unsigned      SYNC_STAGES = 2,
    parameter logic [WIDTH-1:0] OUT_RST     = '0,
    parameter logic [WIDTH-1:0] POL_RST     = 8'hF0,
    parameter logic [WIDTH-1:0] DIR_RST     = '1,
    parameter logic [WIDTH-1:0] OD_MASK     = 8'h01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_idx,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data,
    input  logic             sample_strobe,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] in_cap_q;
    logic [WIDTH-1:0] out_q, pol_q, dir_q;

    gpx_in_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_i(pin_in), .sync_o(pin_sync)
    );

    gpx_cfg_regs #(.WIDTH(WIDTH), .OUT_RST(OUT_RST), .POL_RST(POL_RST), .DIR_RST(DIR_RST)) cfg_i (
        .clk(clk), .rst_n(rst_n), .idx_i(reg_idx), .wr_en_i(wr_en), .wr_data_i(wr_data),
        .out_q(out_q), .pol_q(pol_q), .dir_q(dir_q)
    );

    gpx_pad_ctrl #(.WIDTH(WIDTH), .OD_MASK(OD_MASK)) pad_i (
        .out_i(out_q), .dir_i(dir_q), .pad_out_o(pad_out), .pad_oe_o(pad_oe)
    );

    // Capture the synchronized pins so a read stays stable.
    always_ff @(posedge clk) begin
        if (!rst_n)             in_cap_q <= '0;
        else if (sample_strobe) in_cap_q <= pin_sync;
    end

    // Read mux. Polarity affects only the input view of input pins.
    always_comb begin
        unique case (gpx_idx_e'(reg_idx))
            IDX_IN:  rd_data = in_cap_q ^ (pol_q & dir_q);
            IDX_OUT: rd_data = out_q;
            IDX_POL: rd_data = pol_q;
            default: rd_data = dir_q;
        endcase
    end

    // R5
    cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_strobe |=> $stable(in_cap_q));

    // R8
    od_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_idx == IDX_OUT && wr_data[0]) |=> !pad_oe[0]);
endmodule

// File: tb/gpio_expander_regs_tb.sv
module gpio_expander_regs_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_idx = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sample_strobe = 1'b0;
    logic [7:0] pin_in = '0;
    logic [7:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_out, m_pol, m_dir, m_cap;

    always #2 clk = ~clk;

    gpio_expander_regs dut_i (
        .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .sample_strobe(sample_strobe), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] exp_in(input logic [7:0] cap, pol, dir);
        return cap ^ (pol & dir);
    endfunction
    function automatic logic [7:0] exp_oe(input logic [7:0] o, d);
        return {~d[7:1], ~d[0] & ~o[0]};
    endfunction
    function automatic logic [7:0] exp_po(input logic [7:0] o);
        return {o[7:1], 1'b0};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] i, output logic [7:0] v);
        reg_idx = i;
        #0.5;
        v = rd_data;
    endtask

    task automatic wr(input logic [1:0] i, input logic [7:0] d);
        @(negedge clk);
        reg_idx = i; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (i)
            2'd1: m_out = d;
            2'd2: m_pol = d;
            2'd3: m_dir = d;
            default: ;
        endcase
    endtask

    task automatic sample(input logic [7:0] v);
        @(negedge clk);
        pin_in = v;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        sample_strobe = 1'b1;
        @(negedge clk);
        sample_strobe = 1'b0;
        m_cap = v;
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        rd(2'd0, v); chk({tag, " R5 R6 input view"}, v, exp_in(m_cap, m_pol, m_dir));
        rd(2'd1, v); chk({tag, " R2 R9 out latch"}, v, m_out);
        rd(2'd2, v); chk({tag, " R2 polarity"}, v, m_pol);
        rd(2'd3, v); chk({tag, " R2 direction"}, v, m_dir);
        chk({tag, " R7 R8 pad_oe"}, pad_oe, exp_oe(m_out, m_dir));
        chk({tag, " R7 R8 pad_out"}, pad_out, exp_po(m_out));
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd4242);
        m_out = 8'h00; m_pol = 8'hF0; m_dir = 8'hFF; m_cap = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset defaults
        rd(2'd1, v); chk("R1 out default", v, 8'h00);
        rd(2'd2, v); chk("R1 pol default", v, 8'hF0);
        rd(2'd3, v); chk("R1 dir default", v, 8'hFF);
        chk("R1 pad_oe default", pad_oe, 8'h00);

        // R5 R6: all inputs, default polarity inverts the upper nibble
        sample(8'h5A);
        rd(2'd0, v); chk("R6 default polarity", v, 8'hAA);

        // R3: write to index 0 discarded
        wr(2'd0, 8'h33);
        check_all("R3");

        // R4 R8: pin 0 output low drives, then released by 1
        wr(2'd3, 8'h00);
        wr(2'd1, 8'h00);
        chk("R8 od pulls low oe", pad_oe[0] ? 8'h01 : 8'h00, 8'h01);
        wr(2'd1, 8'h01);
        chk("R8 od released", pad_oe[0] ? 8'h01 : 8'h00, 8'h00);
        chk("R8 od out zero", {7'd0, pad_out[0]}, 8'h00);

        // R6: output pins read uninverted
        wr(2'd2, 8'hFF);
        sample(8'h0F);
        rd(2'd0, v); chk("R6 no invert on outputs", v, 8'h0F);

        // R9: latch read differs from pin
        wr(2'd1, 8'hC3);
        sample(8'h3C);
        rd(2'd1, v); chk("R9 latch not pin", v, 8'hC3);

        // R5: capture holds without strobe
        @(negedge clk); pin_in = 8'hFF;
        repeat (5) @(negedge clk);
        rd(2'd0, v); chk("R5 hold without strobe", v, exp_in(m_cap, m_pol, m_dir));

        // random mix
        for (int k = 0; k < 300; k++) begin
            int unsigned op;
            op = $urandom_range(0, 2);
            if (op == 2) sample(8'($urandom));
            else wr(2'($urandom_range(0, 3)), 8'($urandom));
            check_all("RND R4");
        end

        // R10 reset mid-operation, held
        wr(2'd2, 8'h12);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        m_out = 8'h00; m_pol = 8'hF0; m_dir = 8'hFF; m_cap = 8'h00;
        check_all("R10 in reset");
        @(negedge clk);
        reg_idx = 2'd1; wr_data = 8'hAA; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        check_all("R10 held");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R10 released");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule